// File: doc/BRIEF.md
# DDR3 Power-Up Reset Sequencer

This block walks an external DDR3 device out of reset before the memory controller begins its own initialization. After a start strobe it holds the memory reset line at its asserted level for a minimum time and then releases it. It waits a further interval with clock enable low, inserts a short settle time, and then runs the controller's fixed clock-enable delay. At the end it raises clock enable and a done flag, telling the controller that mode-register programming may begin.

Every delay is given in microseconds. It is turned into a cycle count at elaboration time from a clock-frequency parameter in kHz, rounding up. One silicon variant drives the reset control with inverted sense, so a polarity input selects which level of the reset line counts as asserted. The fixed clock-enable delay has a width parameter. It is loaded with its all-ones value and scaled by a per-family multiplier.

Top module: `ddr3_rstseq`

## Requirements
- R1: After the block reset, and for as long as no start has been accepted, the reset line sits at its asserted level, and clock enable and done are 0.
- R2: A start accepted while idle or done puts the reset line at its asserted level from the next cycle. It stays there for exactly T_RST cycles, and clock enable and done are 0 during that time.
- R3: After the reset line is released, clock enable stays 0 for T_POST + T_SET + T_HW cycles. Clock enable is never 1 while the reset line is at its asserted level.
- R4: The fixed clock-enable delay T_HW lasts (2^HWDLY_W - 1) * HWDLY_N cycles. With HWDLY_W = 4 and HWDLY_N = 3 it is 45 cycles.
- R5: Clock enable and done rise in the same cycle. Both stay 1, with the reset line released, until the next accepted start.
- R6: A start that arrives while the sequence is running, whether a single pulse or held over several cycles, is ignored. Timing and outputs are unchanged.
- R7: A start that arrives while done is 1 restarts the whole sequence from the reset hold.
- R8: The asserted level of the reset line equals inv_pol_i: 0 when inv_pol_i = 0, and 1 when inv_pol_i = 1. The released level is its complement, and the line follows inv_pol_i combinationally.
- R9: Each microsecond delay becomes ceil(us * CLK_KHZ / 1000) cycles, with a minimum of 1. At 2500 kHz, 200 us gives 500 cycles, 500 us gives 1250 cycles and 1 us gives 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| inv_pol_i | input | 1 | Reset polarity select: the asserted level of mem_rst_o |
| mem_rst_o | output | 1 | Reset line to the memory device |
| cke_o | output | 1 | Clock enable to the memory device |
| done_o | output | 1 | Mode-register initialization may start |

## Verification
The sequence is run several ways:
- a plain run from idle, which checks every phase length against counts the bench derives itself;
- a run with single start pulses in the hold phase and a start held for several cycles in the post-release wait, which separates a design that ignores such starts from one that restarts or stretches;
- a restart from the done state with inverted polarity, which shows that a done-state start is accepted and that the asserted level flips;
- a block reset in the middle of a sequence followed by a fresh run, which shows that the idle state comes back at once.

Measured hold and release-to-clock-enable lengths are compared with the rounded-up microsecond conversion and with the scaled fixed delay.

// File: rtl/ddr3_rstseq_pkg.sv
package ddr3_rstseq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_HOLD = 3'd1,
    SQ_POST = 3'd2,
    SQ_SETL = 3'd3,
    SQ_CKED = 3'd4,
    SQ_DONE = 3'd5
  } sq_state_t;

  // Microseconds to cycles, rounded up, never below one cycle.
  function automatic int unsigned us_to_cyc(int unsigned us, int unsigned khz);
    int unsigned c;
    c = (us * khz + 32'd999) / 32'd1000;
    return (c == 0) ? 32'd1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import ddr3_rstseq_pkg::*;
#(
  parameter int unsigned CW     = 8,
  parameter int unsigned T_RST  = 4,
  parameter int unsigned T_POST = 4,
  parameter int unsigned T_SET  = 1,
  parameter int unsigned T_HW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          zero,
  output sq_state_t     state,
  output logic          load,
  output logic [CW-1:0] load_val
);

  localparam logic [CW-1:0] L_RST  = CW'(T_RST  - 1);
  localparam logic [CW-1:0] L_POST = CW'(T_POST - 1);
  localparam logic [CW-1:0] L_SET  = CW'(T_SET  - 1);
  localparam logic [CW-1:0] L_HW   = CW'(T_HW   - 1);

  sq_state_t st_q, st_d;

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_val = '0;
    case (st_q)
      SQ_IDLE, SQ_DONE: begin
        if (start_i) begin
          st_d = SQ_HOLD; load = 1'b1; load_val = L_RST;
        end
      end
      SQ_HOLD: begin
        if (zero) begin
          st_d = SQ_POST; load = 1'b1; load_val = L_POST;
        end
      end
      SQ_POST: begin
        if (zero) begin
          st_d = SQ_SETL; load = 1'b1; load_val = L_SET;
        end
      end
      SQ_SETL: begin
        if (zero) begin
          st_d = SQ_CKED; load = 1'b1; load_val = L_HW;
        end
      end
      SQ_CKED: begin
        if (zero) st_d = SQ_DONE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/rstseq_drv.sv
module rstseq_drv
  import ddr3_rstseq_pkg::*;
(
  input  sq_state_t state,
  input  logic      inv_pol_i,
  output logic      mem_rst_o,
  output logic      cke_o,
  output logic      done_o,
  output logic      busy
);

  logic rst_asserted;

  always_comb begin
    rst_asserted = (state == SQ_IDLE) || (state == SQ_HOLD);
    mem_rst_o    = rst_asserted ? inv_pol_i : ~inv_pol_i;
    cke_o        = (state == SQ_DONE);
    done_o       = (state == SQ_DONE);
    busy         = (state == SQ_HOLD) || (state == SQ_POST) ||
                   (state == SQ_SETL) || (state == SQ_CKED);
  end

endmodule

// File: rtl/ddr3_rstseq.sv
module ddr3_rstseq
  import ddr3_rstseq_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 400000,
  parameter int unsigned RST_US    = 200,
  parameter int unsigned CKE_US    = 500,
  parameter int unsigned SETTLE_US = 1,
  parameter int unsigned HWDLY_W   = 17,
  parameter int unsigned HWDLY_N   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic inv_pol_i,
  output logic mem_rst_o,
  output logic cke_o,
  output logic done_o
);

  localparam int unsigned T_RST  = us_to_cyc(RST_US, CLK_KHZ);
  localparam int unsigned T_POST = us_to_cyc(CKE_US, CLK_KHZ);
  localparam int unsigned T_SET  = us_to_cyc(SETTLE_US, CLK_KHZ);
  localparam int unsigned T_HW   = ((32'd1 << HWDLY_W) - 1) * HWDLY_N;
  localparam int unsigned T_MAX  = max2(max2(T_RST, T_POST), max2(T_SET, T_HW));
  localparam int unsigned CW     = $clog2(T_MAX + 1);

  sq_state_t     state;
  logic          load;
  logic [CW-1:0] load_val;
  logic          zero;
  logic          busy;

  rstseq_fsm #(
    .CW(CW), .T_RST(T_RST), .T_POST(T_POST), .T_SET(T_SET), .T_HW(T_HW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .zero(zero),
    .state(state), .load(load), .load_val(load_val)
  );

  rstseq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(zero)
  );

  rstseq_drv u_drv (
    .state(state), .inv_pol_i(inv_pol_i),
    .mem_rst_o(mem_rst_o), .cke_o(cke_o), .done_o(done_o), .busy(busy)
  );

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic inv_pol_i,
  input logic mem_rst_o,
  input logic cke_o,
  input logic done_o,
  input logic busy
);

  // R1
  p_idle_asserted_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done_o) |-> (mem_rst_o == inv_pol_i) && !cke_o);

  // R2
  p_start_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> ((mem_rst_o == inv_pol_i) || !$stable(inv_pol_i)) && !cke_o && !done_o);

  // R3
  p_cke_needs_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o |-> (mem_rst_o != inv_pol_i));

  // R5
  p_cke_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $rose(cke_o));

  // R5
  p_done_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o && cke_o);

  // R6
  p_busy_ignores_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && (mem_rst_o != inv_pol_i)) |=>
      ((mem_rst_o != inv_pol_i) || !$stable(inv_pol_i)));

endmodule

bind ddr3_rstseq rstseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .inv_pol_i(inv_pol_i),
  .mem_rst_o(mem_rst_o), .cke_o(cke_o), .done_o(done_o), .busy(busy)
);

// File: tb/test_ddr3_rstseq.sv
module test_ddr3_rstseq;

  localparam int KHZ   = 2500;
  localparam int HW_W  = 4;
  localparam int HW_N  = 3;
  localparam int E_RST  = (200 * KHZ + 999) / 1000;
  localparam int E_POST = (500 * KHZ + 999) / 1000;
  localparam int E_SET  = (1 * KHZ + 999) / 1000;
  localparam int E_HW   = (2 ** HW_W - 1) * HW_N;
  localparam int E_TOT  = E_RST + E_POST + E_SET + E_HW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic inv_pol_i = 1'b0;
  logic mem_rst_o, cke_o, done_o;

  always #10 clk = ~clk;

  ddr3_rstseq #(
    .CLK_KHZ(KHZ), .RST_US(200), .CKE_US(500), .SETTLE_US(1),
    .HWDLY_W(HW_W), .HWDLY_N(HW_N)
  ) i_ddr3_rstseq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .inv_pol_i(inv_pol_i),
    .mem_rst_o(mem_rst_o), .cke_o(cke_o), .done_o(done_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference: elapsed cycles since the accepted start.
  bit   m_act = 0, m_fin = 0, f6 = 0, f7 = 0;
  int   t = 0, m_hold = 0, m_wait = 0;
  logic pd = 1'b0;
  logic e_ass, e_line;
  string tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_fin = 0; f6 = 0; f7 = 0;
    end else if (m_act) begin
      if (start_i) f6 = 1;
      t++;
      if (t == E_TOT) begin m_act = 0; m_fin = 1; end
    end else if (start_i) begin
      f7 = m_fin; f6 = 0;
      m_act = 1; m_fin = 0; t = 0; m_hold = 0; m_wait = 0;
    end
    #5;
    e_ass  = !m_fin && (!m_act || t < E_RST);
    e_line = e_ass ? inv_pol_i : ~inv_pol_i;
    if (f6)                          tag = "R6";
    else if (f7)                     tag = "R7";
    else if (!m_act && !m_fin)       tag = "R1";
    else if (m_fin)                  tag = "R5";
    else if (t < E_RST)              tag = inv_pol_i ? "R8" : "R2";
    else                             tag = "R3";
    chk({tag, " reset line"}, 32'(mem_rst_o), 32'(e_line));
    chk({tag, " cke"},        32'(cke_o),     32'(m_fin));
    chk({tag, " done"},       32'(done_o),    32'(m_fin));
    if (m_act) begin
      if (mem_rst_o === inv_pol_i) m_hold++;
      else if (cke_o !== 1'b1)     m_wait++;
    end
    if (done_o === 1'b1 && pd !== 1'b1) begin
      chk("R9 hold length", 32'(m_hold), 32'(E_RST));
      chk("R4 release to cke length", 32'(m_wait), 32'(E_POST + E_SET + E_HW));
    end
    pd = done_o;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);                     // R1 idle state
    pulse();                     // R2, R3, R4, R5, R9 plain run
    idle(E_TOT + 10);
    pulse();                     // R6: extra starts while running
    idle(100);
    pulse();
    idle(E_RST + 300);
    @(negedge clk) start_i = 1'b1;
    idle(3);
    start_i = 1'b0;
    idle(E_TOT);
    inv_pol_i = 1'b1;            // R8 polarity flip while done
    idle(3);
    pulse();                     // R7 restart from done
    idle(300);
    rst_n = 1'b0;                // block reset mid-sequence
    idle(2);
    rst_n = 1'b1;
    idle(5);
    pulse();
    idle(E_TOT + 5);
    inv_pol_i = 1'b0;
    idle(3);
    summary();
    $finish;
  end

endmodule